// File: doc/BRIEF.md
# NOR Flash Program/Erase Array Controller

This block models a small sector-organised NOR flash array and the controller that applies program and erase requests to it. Each byte cell can only move bits from one to zero when programmed. Only an erase of the whole sector containing it brings it back to all ones. Before a program request is applied, the controller compares it with the stored byte. The request is carried out only if every one bit it asks for is still a one in the cell. Otherwise the request is refused and the cell is left exactly as it was.

Requests arrive on a valid/ready channel. A request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as an operation runs. A request shown while `req_ready` is low is not taken, not queued and has no effect, and the requester may drop `req_valid` at any time. Once the operation has finished, `done` pulses for one cycle and `status` gives its result, which holds until the next `done`.

The block has two further ports. A combinational lookup port takes any address and returns its sector number with that sector's first and last addresses. A combinational read port returns the stored byte at an array address.

Top module: `nor_array_ctrl`

## Requirements
- R1: After reset every byte of the 4 x 64-byte array reads 0xFF, `busy` and `done` are 0, `req_ready` is 1 and `status` is 0 (OK).
- R2: A program request (`req_op` = 2'b01) whose data is reachable from the stored byte, meaning (~stored & data) == 0, leaves stored & data in the byte and reports status 0 (OK). No program ever sets a bit.
- R3: A program request whose data sets a bit that is already clear reports status 1 (cannot-write) and leaves the whole array unchanged.
- R4: The same byte may be programmed again without an erase, and each request that only clears further bits succeeds.
- R5: An erase request (`req_op` = 2'b10) sets all 64 bytes of the addressed sector (address bits [7:6]) to 0xFF, leaves the other sectors unchanged and reports status 0.
- R6: A combined request (`req_op` = 2'b11) erases the sector first and then programs the byte. Because the erase has already run, it always reports status 0 and leaves the data in the byte and 0xFF in the rest of the sector.
- R7: The lookup port returns `lk_hit` = 1, sector = address / 64, first = sector * 64 and last = first + 63 for addresses below 256. For any other address it returns all zeros.
- R8: A program or erase request to an address of 256 or above reports status 2 (address error) and changes nothing.
- R9: A request with `req_op` = 2'b00 reports status 3 (bad op) and changes nothing.
- R10: After the accepting edge, `busy` stays high for exactly 2 cycles for a program, 64 for an erase, 66 for both, and 1 for a rejected request. In the next cycle `done` is high for exactly one cycle while `busy` is low. `req_ready` equals not `busy`, and `status` changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 2 | Bit 0 program, bit 1 erase |
| req_addr | input | 10 | Byte address of the request |
| req_data | input | 8 | Value to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | 0 OK, 1 cannot-write, 2 address error, 3 bad op |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| lk_addr | input | 10 | Address to look up |
| lk_hit | output | 1 | Address lies inside the array |
| lk_sector | output | 2 | Sector number |
| lk_first | output | 10 | First address of the sector |
| lk_last | output | 10 | Last address of the sector |

## Verification
The bench takes the request on the rising edge and then samples on each falling edge. It counts the cycles with `busy` high until `done` appears, which should be 2, 64, 66 or 1 cycles after acceptance depending on the request. It checks that `status` is valid in the `done` cycle and that `done` is low on the following falling edge. The array contents already hold the result in the `done` cycle, so the read port is compared with the bench model only after `done`. The lookup and read ports are combinational, so they are checked a short delay after their address is driven on a falling edge.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NOWRITE = 2'd1,
    ST_BADADDR = 2'd2,
    ST_BADOP   = 2'd3
  } fa_status_e;

  localparam int OP_PGM_BIT = 0;
  localparam int OP_ERS_BIT = 1;
endpackage

// File: rtl/nfa_sector_map.sv
module nfa_sector_map #(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 64,
  parameter int ADDR_W       = 10
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [$clog2(SECTORS)-1:0] sector,
  output logic [ADDR_W-1:0]          first,
  output logic [ADDR_W-1:0]          last
);
  localparam int DEPTH  = SECTORS * SECTOR_BYTES;
  localparam int SEC_AW = $clog2(SECTOR_BYTES);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int MEM_AW = SEC_AW + SEC_W;

  logic [SEC_W-1:0] sec_raw;

  always_comb begin
    hit     = int'(addr) < DEPTH;
    sec_raw = addr[SEC_AW +: SEC_W];
    sector  = hit ? sec_raw : '0;
    first   = hit ? ADDR_W'({sec_raw, {SEC_AW{1'b0}}}) : '0;
    last    = hit ? ADDR_W'({sec_raw, {SEC_AW{1'b1}}}) : '0;
  end

  // MEM_AW documents the in-array address width used by the bounds above
  if (MEM_AW > ADDR_W) begin : g_bad_width
    initial $display("nfa_sector_map: ADDR_W narrower than array address");
  end
endmodule

// File: rtl/nfa_array.sv
module nfa_array #(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 64
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       ers_en,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]   ers_addr,
  input  logic                                       pgm_en,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]   pgm_addr,
  input  logic [7:0]                                 pgm_data,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]   chk_addr,
  output logic [7:0]                                 chk_data,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]   rd_addr,
  output logic [7:0]                                 rd_data
);
  localparam int DEPTH = SECTORS * SECTOR_BYTES;

  logic [7:0] cells [DEPTH];

  // Cells only lose ones on program; erase is the sole path back to 0xFF
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else begin
      if (ers_en) cells[ers_addr] <= 8'hFF;
      if (pgm_en) cells[pgm_addr] <= cells[pgm_addr] & pgm_data;
    end
  end

  assign chk_data = cells[chk_addr];
  assign rd_data  = cells[rd_addr];

  p_erase_sets_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ers_en |=> cells[$past(ers_addr)] == 8'hFF);

  p_pgm_never_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> (cells[$past(pgm_addr)] & ~$past(cells[pgm_addr])) == 8'h00);

  p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ers_en && pgm_en));
endmodule

// File: rtl/nfa_sequencer.sv
module nfa_sequencer
  import nfa_pkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 64,
  parameter int ADDR_W       = 10
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [1:0]                               req_op,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [7:0]                               req_data,
  output logic                                     busy,
  output logic                                     done,
  output logic [1:0]                               status,
  output logic                                     ers_en,
  output logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  ers_addr,
  output logic                                     pgm_en,
  output logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  pgm_addr,
  output logic [7:0]                               pgm_data,
  output logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  chk_addr,
  input  logic [7:0]                               chk_data
);
  localparam int DEPTH  = SECTORS * SECTOR_BYTES;
  localparam int SEC_AW = $clog2(SECTOR_BYTES);
  localparam int MEM_AW = $clog2(DEPTH);

  typedef enum logic [2:0] {
    S_IDLE, S_REJECT, S_ERASE, S_CHECK, S_WRITE, S_FINISH
  } seq_state_e;

  seq_state_e        state;
  logic [MEM_AW-1:0] addr_q;
  logic [7:0]        data_q;
  logic              pgm_q;
  logic              ok_q;
  logic [SEC_AW-1:0] idx;
  fa_status_e        rej_q;
  fa_status_e        status_q;
  logic              in_range;
  logic              take;

  assign in_range  = int'(req_addr) < DEPTH;
  assign busy      = (state != S_IDLE) && (state != S_FINISH);
  assign req_ready = !busy;
  assign done      = state == S_FINISH;
  assign take      = req_valid && req_ready;
  assign status    = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      pgm_q    <= 1'b0;
      ok_q     <= 1'b0;
      idx      <= '0;
      rej_q    <= ST_OK;
      status_q <= ST_OK;
    end else begin
      unique case (state)
        S_IDLE, S_FINISH: begin
          state <= S_IDLE;
          if (take) begin
            addr_q <= req_addr[MEM_AW-1:0];
            data_q <= req_data;
            pgm_q  <= req_op[OP_PGM_BIT];
            idx    <= '0;
            if (req_op == 2'b00) begin
              state <= S_REJECT;
              rej_q <= ST_BADOP;
            end else if (!in_range) begin
              state <= S_REJECT;
              rej_q <= ST_BADADDR;
            end else if (req_op[OP_ERS_BIT]) begin
              state <= S_ERASE;
            end else begin
              state <= S_CHECK;
            end
          end
        end
        S_REJECT: begin
          state    <= S_FINISH;
          status_q <= rej_q;
        end
        S_ERASE: begin
          idx <= idx + 1'b1;
          if (idx == '1) begin
            if (pgm_q) begin
              state <= S_CHECK;
            end else begin
              state    <= S_FINISH;
              status_q <= ST_OK;
            end
          end
        end
        S_CHECK: begin
          ok_q  <= ((~chk_data) & data_q) == 8'h00;
          state <= S_WRITE;
        end
        S_WRITE: begin
          state    <= S_FINISH;
          status_q <= ok_q ? ST_OK : ST_NOWRITE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ers_en   = state == S_ERASE;
  assign ers_addr = {addr_q[MEM_AW-1:SEC_AW], idx};
  assign pgm_en   = (state == S_WRITE) && ok_q;
  assign pgm_addr = addr_q;
  assign pgm_data = data_q;
  assign chk_addr = addr_q;

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_no_unreachable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |-> ((~chk_data) & pgm_data) == 8'h00);

  p_bad_addr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op != 2'b00 && !in_range) |=> (busy && !ers_en && !pgm_en) ##1 (done && status == 2'd2));
endmodule

// File: rtl/nor_array_ctrl.sv
module nor_array_ctrl #(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 64,
  parameter int ADDR_W       = 10
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [1:0]                               req_op,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [7:0]                               req_data,
  output logic                                     busy,
  output logic                                     done,
  output logic [1:0]                               status,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  rd_addr,
  output logic [7:0]                               rd_data,
  input  logic [ADDR_W-1:0]                        lk_addr,
  output logic                                     lk_hit,
  output logic [$clog2(SECTORS)-1:0]               lk_sector,
  output logic [ADDR_W-1:0]                        lk_first,
  output logic [ADDR_W-1:0]                        lk_last
);
  localparam int MEM_AW = $clog2(SECTORS * SECTOR_BYTES);

  logic              ers_en, pgm_en;
  logic [MEM_AW-1:0] ers_addr, pgm_addr, chk_addr;
  logic [7:0]        pgm_data, chk_data;

  nfa_sequencer #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .status(status),
    .ers_en(ers_en), .ers_addr(ers_addr),
    .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .chk_addr(chk_addr), .chk_data(chk_data)
  );

  nfa_array #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .ers_en(ers_en), .ers_addr(ers_addr),
    .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .chk_addr(chk_addr), .chk_data(chk_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  nfa_sector_map #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)
  ) u_lookup (
    .addr(lk_addr), .hit(lk_hit), .sector(lk_sector),
    .first(lk_first), .last(lk_last)
  );

  p_status_moves_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |-> done);
endmodule

// File: tb/nor_array_ctrl_bench.sv
module nor_array_ctrl_bench;
  localparam int SECTORS = 4, SECTOR_BYTES = 64, ADDR_W = 10, DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0]        req_data = '0;
  logic              busy, done;
  logic [1:0]        status;
  logic [7:0]        rd_addr = '0, rd_data;
  logic [ADDR_W-1:0] lk_addr = '0, lk_first, lk_last;
  logic              lk_hit;
  logic [1:0]        lk_sector;

  nor_array_ctrl u_nor_array_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_sector(lk_sector),
    .lk_first(lk_first), .lk_last(lk_last)
  );

  int checks = 0, fails = 0;
  logic [7:0] model [DEPTH];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_apply(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                                             input logic [7:0] d, output int cyc);
    logic [1:0] st;
    int base;
    if (op == 2'b00) begin cyc = 1; return 2'd3; end
    if (int'(a) >= DEPTH) begin cyc = 1; return 2'd2; end
    cyc = 0; st = 2'd0;
    if (op[1]) begin
      base = (int'(a) / SECTOR_BYTES) * SECTOR_BYTES;
      for (int i = 0; i < SECTOR_BYTES; i++) model[base + i] = 8'hFF;
      cyc += SECTOR_BYTES;
    end
    if (op[0]) begin
      cyc += 2;
      if (((~model[a[7:0]]) & d) != 8'h00) st = 2'd1;
      else model[a[7:0]] = model[a[7:0]] & d;
    end
    return st;
  endfunction

  task automatic run_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [7:0] d, input string tag);
    int exp_cyc, n;
    logic [1:0] exp_st;
    exp_st = model_apply(op, a, d, exp_cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      if (busy) n++;
      @(negedge clk);
    end
    chk({"R10 busy length ", tag}, n, exp_cyc);
    chk({tag, " status"}, status, exp_st);
    chk("R10 ready in done cycle", req_ready, 1'b1);
    if (int'(a) < DEPTH) begin
      rd_addr = a[7:0];
      #1 chk({tag, " stored byte"}, rd_data, model[a[7:0]]);
    end
    @(negedge clk);
    chk("R10 done single pulse", done, 1'b0);
  endtask

  task automatic full_compare(input string tag);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = 8'(i);
      #1 if (rd_data !== model[i]) begin
        if (bad == 0) $display("FAIL %s: byte %0d actual %0h expected %0h", tag, i, rd_data, model[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic check_lookup(input logic [ADDR_W-1:0] a);
    int s;
    @(negedge clk);
    lk_addr = a;
    #1;
    if (int'(a) < DEPTH) begin
      s = int'(a) / SECTOR_BYTES;
      chk("R7 hit", lk_hit, 1'b1);
      chk("R7 sector", lk_sector, s);
      chk("R7 first", lk_first, s * SECTOR_BYTES);
      chk("R7 last", lk_last, s * SECTOR_BYTES + SECTOR_BYTES - 1);
    end else begin
      chk("R7 miss", {lk_hit, lk_sector, lk_first, lk_last}, 0);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [ADDR_W-1:0] a;
    logic [7:0] d;
    logic [1:0] op;
    int r;
    void'($urandom(32'd7719));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 status", status, 2'd0);
    chk("R1 ready", req_ready, 1'b1);
    full_compare("R1 array all ones");

    // R2, R4, R3 on one byte
    run_req(2'b01, 10'h010, 8'hA5, "R2 program reachable");
    run_req(2'b01, 10'h010, 8'h24, "R4 reprogram clears more");
    run_req(2'b01, 10'h010, 8'hFF, "R3 cannot-write");
    full_compare("R3 array unchanged");

    // R5: erase sector 0 via its last address
    run_req(2'b01, 10'h050, 8'h00, "R2 program other sector");
    run_req(2'b10, 10'h03F, 8'h00, "R5 erase");
    full_compare("R5 only sector 0 restored");

    // R6: erase then program together
    run_req(2'b01, 10'h0A0, 8'h0F, "R2 program before combined");
    run_req(2'b11, 10'h090, 8'h3C, "R6 erase then program");
    full_compare("R6 sector contents");

    // R8, R9
    run_req(2'b01, 10'h100, 8'h00, "R8 address error");
    run_req(2'b10, 10'h3FF, 8'h00, "R8 address error erase");
    run_req(2'b00, 10'h020, 8'h00, "R9 bad op");
    full_compare("R8 R9 array unchanged");

    // R10: request offered while busy is not taken
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_addr = 10'h0C0; req_data = 8'h00;
    @(negedge clk);
    req_op = 2'b01; req_addr = 10'h005; req_data = 8'h00;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    void'(model_apply(2'b10, 10'h0C0, 8'h00, n));
    while (!done) @(negedge clk);
    chk("R10 status after erase", status, 2'd0);
    repeat (3) @(negedge clk);
    chk("R10 no second operation", {busy, done}, 2'b00);
    full_compare("R10 busy request ignored");

    // R7 directed lookups
    check_lookup(10'h000);
    check_lookup(10'h03F);
    check_lookup(10'h040);
    check_lookup(10'h0FF);
    check_lookup(10'h100);

    // Constrained random mix
    for (int k = 0; k < 150; k++) begin
      r = int'($urandom % 16);
      if (r == 0) op = 2'b00;
      else if (r < 3) op = 2'b10;
      else if (r == 3) op = 2'b11;
      else op = 2'b01;
      if ($urandom % 10 == 0) a = ADDR_W'(DEPTH + ($urandom % 768));
      else a = ADDR_W'($urandom % DEPTH);
      d = 8'($urandom);
      if (int'(a) < DEPTH && ($urandom % 2 == 0)) d = d & model[a[7:0]];
      run_req(op, a, d, "R2 R3 R5 R6 random");
      if (k % 25 == 0) full_compare("R2 R3 R5 random array");
      check_lookup(ADDR_W'($urandom));
    end
    full_compare("R5 final array");

    summary();
    $finish;
  end
endmodule